// File: doc/BRIEF.md
# Flow Table Entry Read-Back Controller

This block copies a single flow-table entry out of an on-chip entry memory. The memory sits behind an indirect register window. A host gives an entry index and pulses `start`. The controller picks which of two lookup engines owns the entry and writes that engine's control register once, carrying the index and a request flag. It then polls the same register until the memory reports an acknowledge. After the acknowledge it reads the entry's data registers word by word and streams each word out with its position.

Indices at or beyond the on-chip entry count live in external memory. They need no read-back, so they finish at once without any register traffic. The acknowledge poll runs on a fixed cycle interval and has an overall cycle budget. If the budget runs out, the operation ends with an error flag and streams no data. The register bus is a plain read/write port. Read data returns exactly one cycle after the read strobe.

Top module: `entry_readback_ctrl`

## Requirements
- R1: After reset, `busy`, `done`, `word_valid`, `timeout_err`, `bus_wr` and `bus_rd` are all low.
- R2: A start with `index` at or above ONCHIP_ENTRIES (16384 by default) makes no bus access and streams no words. It raises `done` in the cycle after the start.
- R3: When `dual_en` is high and `index` is at or above ONCHIP_ENTRIES/2 (8192), every access goes to engine 1. Engine 1's control register is at 0x0300 and its data word k is at 0x0304+4k. Otherwise engine 0 is used, with control at 0x0200 and data word k at 0x0204+4k.
- R4: For an in-range index, exactly one bus write is issued, in the cycle after the start. It targets the chosen control register with write data equal to the index in bits [15:0], bit 16 (request) set, and all other bits zero.
- R5: The first poll read of the control register comes in the cycle after the write. Later poll reads come exactly POLL_INTERVAL cycles apart. Bit 17 of the read data, which returns one cycle after the read, is the acknowledge.
- R6: Let elapsed be 1 at the first poll check, counting cycles from the first poll read. If no acknowledge has been seen at a check where elapsed has reached TIMEOUT_CYC, the operation ends with `done` and `timeout_err` high. No data reads and no words occur. With an interval of 8 and a budget of 40, that is six poll reads.
- R7: After the acknowledge, ENTRY_WORDS (20) data reads follow on consecutive cycles, word 0 first, in ascending address order.
- R8: Each word read appears on `word_data` with `word_valid` high two cycles after its read. `word_idx` equals the word number, so the words come out in ascending order with no gaps.
- R9: `done` is a one-cycle pulse. On success it coincides with the last word. `busy` is high from the cycle after an accepted start through the `done` cycle and is low in the following cycle.
- R10: A `start` while `busy` is high is ignored. It starts no new operation, does not change the index in flight, and causes no second `done`.
- R11: `timeout_err` stays high after a timeout until the next accepted start, which clears it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a read-back of `index` |
| index | input | IDX_W | Entry index to fetch |
| dual_en | input | 1 | Two-engine table split enabled |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| timeout_err | output | 1 | Last operation ran out of poll budget |
| word_valid | output | 1 | Entry word strobe |
| word_idx | output | WORD_W | Position of the word within the entry |
| word_data | output | DATA_W | Entry word |
| bus_wr | output | 1 | Register write strobe |
| bus_rd | output | 1 | Register read strobe |
| bus_addr | output | ADDR_W | Register address |
| bus_wdata | output | DATA_W | Register write data |
| bus_rdata | input | DATA_W | Register read data, valid one cycle after `bus_rd` |

## Verification
Several properties are checked on every cycle:
- single-cycle write strobes that carry the request flag;
- writes and reads never overlapping, and no bus activity while idle;
- `done` being a lone pulse followed by idle;
- `busy` not dropping before `done`;
- an error appearing only together with `done`;
- word indices stepping by one across back-to-back words.

Only the bench scenarios can show the rest: the engine choice around the half-table boundary with and without the dual setting, the exact poll spacing and poll count before a timeout, and the data addresses and word contents matching the register model. They also show that a start pressed mid-operation leaves the result untouched.

// File: rtl/rb_pkg.sv
package rb_pkg;
  typedef enum logic [2:0] {
    S_IDLE     = 3'd0,
    S_REQ      = 3'd1,
    S_POLL_RD  = 3'd2,
    S_POLL_CHK = 3'd3,
    S_WAIT     = 3'd4,
    S_DATA     = 3'd5,
    S_DRAIN    = 3'd6,
    S_FIN      = 3'd7
  } rb_state_e;
endpackage

// File: rtl/rb_reg_map.sv
module rb_reg_map #(
  parameter int IDX_W          = 16,
  parameter int ADDR_W         = 16,
  parameter int WORD_W         = 5,
  parameter int ONCHIP_ENTRIES = 16384,
  parameter logic [ADDR_W-1:0] CTRL_BASE     = 16'h0200,
  parameter logic [ADDR_W-1:0] DATA_BASE     = 16'h0204,
  parameter logic [ADDR_W-1:0] ENGINE_STRIDE = 16'h0100
) (
  input  logic [IDX_W-1:0]  req_idx,
  input  logic              dual_en,
  input  logic              eng_q,
  input  logic [WORD_W-1:0] word_k,
  output logic              in_range,
  output logic              eng_pick,
  output logic [ADDR_W-1:0] ctrl_addr,
  output logic [ADDR_W-1:0] data_addr
);
  localparam logic [IDX_W:0] LIMIT = (IDX_W+1)'(ONCHIP_ENTRIES);
  localparam logic [IDX_W:0] HALF  = (IDX_W+1)'(ONCHIP_ENTRIES / 2);

  logic [ADDR_W-1:0] eng_off [2];

  // one register window per engine
  for (genvar g = 0; g < 2; g++) begin : g_eng
    assign eng_off[g] = ENGINE_STRIDE * ADDR_W'(g);
  end

  always_comb begin
    in_range  = {1'b0, req_idx} < LIMIT;
    eng_pick  = dual_en && ({1'b0, req_idx} >= HALF);
    ctrl_addr = CTRL_BASE + eng_off[eng_q];
    data_addr = DATA_BASE + eng_off[eng_q] + (ADDR_W'(word_k) << 2);
  end
endmodule

// File: rtl/rb_poll_timer.sv
module rb_poll_timer #(
  parameter int POLL_INTERVAL = 1000,
  parameter int TIMEOUT_CYC   = 10000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic elapsed_clr,
  input  logic elapsed_run,
  input  logic gap_clr,
  input  logic gap_run,
  output logic expired,
  output logic gap_done
);
  localparam int EL_W  = $clog2(TIMEOUT_CYC + 1);
  localparam int GAP_W = (POLL_INTERVAL > 2) ? $clog2(POLL_INTERVAL) : 1;
  localparam logic [EL_W-1:0]  EL_LIMIT = EL_W'(TIMEOUT_CYC);
  localparam logic [GAP_W-1:0] GAP_LAST = GAP_W'(POLL_INTERVAL - 3);

  logic [EL_W-1:0]  el_q, el_d;
  logic             el_en;
  logic [GAP_W-1:0] gap_q, gap_d;
  logic             gap_en;

  always_comb begin
    el_d  = el_q;
    el_en = 1'b0;
    if (elapsed_clr) begin
      el_d  = '0;
      el_en = 1'b1;
    end else if (elapsed_run && (el_q != EL_LIMIT)) begin
      el_d  = el_q + 1'b1;
      el_en = 1'b1;
    end
  end

  always_comb begin
    gap_d  = gap_q;
    gap_en = 1'b0;
    if (gap_clr) begin
      gap_d  = '0;
      gap_en = (gap_q != '0);
    end else if (gap_run) begin
      gap_d  = gap_q + 1'b1;
      gap_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      el_q  <= '0;
      gap_q <= '0;
    end else begin
      if (el_en)  el_q  <= el_d;
      if (gap_en) gap_q <= gap_d;
    end
  end

  assign expired  = (el_q >= EL_LIMIT);
  assign gap_done = (gap_q == GAP_LAST);
endmodule

// File: rtl/rb_word_seq.sv
module rb_word_seq #(
  parameter int DATA_W      = 32,
  parameter int ENTRY_WORDS = 20,
  parameter int WORD_W      = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              issue_en,
  input  logic [DATA_W-1:0] rd_data,
  output logic [WORD_W-1:0] issue_k,
  output logic              last_issue,
  output logic              word_valid,
  output logic [WORD_W-1:0] word_idx,
  output logic [DATA_W-1:0] word_data
);
  localparam logic [WORD_W-1:0] LAST_K = WORD_W'(ENTRY_WORDS - 1);

  logic [WORD_W-1:0] k_q, k_d;
  logic              k_en;
  logic              pend_q;
  logic [WORD_W-1:0] pend_k_q;
  logic              wv_q;
  logic [WORD_W-1:0] widx_q;
  logic [DATA_W-1:0] wdat_q;

  always_comb begin
    k_d  = issue_en ? (k_q + 1'b1) : '0;
    k_en = issue_en || (k_q != '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      k_q      <= '0;
      pend_q   <= 1'b0;
      pend_k_q <= '0;
      wv_q     <= 1'b0;
      widx_q   <= '0;
      wdat_q   <= '0;
    end else begin
      if (k_en) k_q <= k_d;
      pend_q <= issue_en;
      if (issue_en) pend_k_q <= k_q;
      wv_q <= pend_q;
      if (pend_q) begin
        widx_q <= pend_k_q;
        wdat_q <= rd_data;
      end
    end
  end

  assign issue_k    = k_q;
  assign last_issue = (k_q == LAST_K);
  assign word_valid = wv_q;
  assign word_idx   = widx_q;
  assign word_data  = wdat_q;
endmodule

// File: rtl/entry_readback_ctrl.sv
module entry_readback_ctrl #(
  parameter int DATA_W         = 32,
  parameter int ADDR_W         = 16,
  parameter int IDX_W          = 16,
  parameter int ONCHIP_ENTRIES = 16384,
  parameter int ENTRY_WORDS    = 20,
  parameter int POLL_INTERVAL  = 1000,
  parameter int TIMEOUT_CYC    = 10000,
  parameter int REQ_BIT        = 16,
  parameter int ACK_BIT        = 17,
  parameter logic [ADDR_W-1:0] CTRL_BASE     = 16'h0200,
  parameter logic [ADDR_W-1:0] DATA_BASE     = 16'h0204,
  parameter logic [ADDR_W-1:0] ENGINE_STRIDE = 16'h0100,
  localparam int WORD_W = (ENTRY_WORDS > 1) ? $clog2(ENTRY_WORDS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [IDX_W-1:0]  index,
  input  logic              dual_en,
  output logic              busy,
  output logic              done,
  output logic              timeout_err,
  output logic              word_valid,
  output logic [WORD_W-1:0] word_idx,
  output logic [DATA_W-1:0] word_data,
  output logic              bus_wr,
  output logic              bus_rd,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic [DATA_W-1:0] bus_rdata
);
  import rb_pkg::*;

  rb_state_e         state_q, state_d;
  logic [IDX_W-1:0]  idx_q;
  logic              eng_q;
  logic              err_q, err_d, err_en;
  logic              accept;
  logic              in_range, eng_pick;
  logic [ADDR_W-1:0] ctrl_addr, data_addr;
  logic              expired, gap_done;
  logic [WORD_W-1:0] issue_k;
  logic              last_issue;
  logic              ack_seen;

  rb_reg_map #(
    .IDX_W(IDX_W), .ADDR_W(ADDR_W), .WORD_W(WORD_W),
    .ONCHIP_ENTRIES(ONCHIP_ENTRIES), .CTRL_BASE(CTRL_BASE),
    .DATA_BASE(DATA_BASE), .ENGINE_STRIDE(ENGINE_STRIDE)
  ) u_map (
    .req_idx(index), .dual_en(dual_en), .eng_q(eng_q), .word_k(issue_k),
    .in_range(in_range), .eng_pick(eng_pick),
    .ctrl_addr(ctrl_addr), .data_addr(data_addr)
  );

  rb_poll_timer #(
    .POLL_INTERVAL(POLL_INTERVAL), .TIMEOUT_CYC(TIMEOUT_CYC)
  ) u_timer (
    .clk(clk), .rst_n(rst_n),
    .elapsed_clr(state_q == S_REQ),
    .elapsed_run((state_q == S_POLL_RD) || (state_q == S_POLL_CHK) || (state_q == S_WAIT)),
    .gap_clr(state_q != S_WAIT),
    .gap_run(state_q == S_WAIT),
    .expired(expired), .gap_done(gap_done)
  );

  rb_word_seq #(
    .DATA_W(DATA_W), .ENTRY_WORDS(ENTRY_WORDS), .WORD_W(WORD_W)
  ) u_words (
    .clk(clk), .rst_n(rst_n),
    .issue_en(state_q == S_DATA), .rd_data(bus_rdata),
    .issue_k(issue_k), .last_issue(last_issue),
    .word_valid(word_valid), .word_idx(word_idx), .word_data(word_data)
  );

  assign accept   = (state_q == S_IDLE) && start;
  assign ack_seen = bus_rdata[ACK_BIT];

  // next-state
  always_comb begin
    state_d = state_q;
    err_d   = err_q;
    err_en  = 1'b0;
    unique case (state_q)
      S_IDLE: begin
        if (start) begin
          state_d = in_range ? S_REQ : S_FIN;
          err_d   = 1'b0;
          err_en  = 1'b1;
        end
      end
      S_REQ:     state_d = S_POLL_RD;
      S_POLL_RD: state_d = S_POLL_CHK;
      S_POLL_CHK: begin
        if (ack_seen) begin
          state_d = S_DATA;
        end else if (expired) begin
          state_d = S_FIN;
          err_d   = 1'b1;
          err_en  = 1'b1;
        end else begin
          state_d = S_WAIT;
        end
      end
      S_WAIT:  if (gap_done) state_d = S_POLL_RD;
      S_DATA:  if (last_issue) state_d = S_DRAIN;
      S_DRAIN: state_d = S_FIN;
      S_FIN:   state_d = S_IDLE;
      default: state_d = S_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      idx_q   <= '0;
      eng_q   <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      if (accept) begin
        idx_q <= index;
        eng_q <= eng_pick;
      end
      if (err_en) err_q <= err_d;
    end
  end

  // bus drive
  always_comb begin
    bus_wr    = (state_q == S_REQ);
    bus_rd    = (state_q == S_POLL_RD) || (state_q == S_DATA);
    bus_addr  = '0;
    bus_wdata = '0;
    if ((state_q == S_REQ) || (state_q == S_POLL_RD)) bus_addr = ctrl_addr;
    else if (state_q == S_DATA)                         bus_addr = data_addr;
    if (state_q == S_REQ) begin
      bus_wdata[IDX_W-1:0] = idx_q;
      bus_wdata[REQ_BIT]   = 1'b1;
    end
  end

  assign busy        = (state_q != S_IDLE);
  assign done        = (state_q == S_FIN);
  assign timeout_err = err_q;
endmodule

// File: rtl/rb_readback_checks.sv
module rb_readback_checks #(
  parameter int DATA_W  = 32,
  parameter int WORD_W  = 5,
  parameter int REQ_BIT = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              done,
  input logic              timeout_err,
  input logic              word_valid,
  input logic [WORD_W-1:0] word_idx,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [DATA_W-1:0] bus_wdata
);
  a_r4_single_write: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr |=> !bus_wr);
  a_r4_req_flag: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr |-> bus_wdata[REQ_BIT]);
  a_r1_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr && bus_rd));
  a_r2_quiet_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!bus_wr && !bus_rd));
  a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r9_idle_after_done: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);
  a_r10_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> busy);
  a_r8_word_order: assert property (@(posedge clk) disable iff (!rst_n)
    (word_valid && $past(word_valid)) |-> (word_idx == WORD_W'($past(word_idx) + 1'b1)));
  a_r6_no_words_on_error: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_err |-> !word_valid);
  a_r11_error_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(timeout_err) |-> done);
endmodule

bind entry_readback_ctrl rb_readback_checks #(
  .DATA_W(DATA_W), .WORD_W(WORD_W), .REQ_BIT(REQ_BIT)
) u_checks (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done),
  .timeout_err(timeout_err), .word_valid(word_valid), .word_idx(word_idx),
  .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata)
);

// File: tb/tb_entry_readback_ctrl.sv
module tb_entry_readback_ctrl;
  localparam int NW = 20;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start;
  logic [15:0] index;
  logic        dual_en;
  logic        busy, done, timeout_err, word_valid;
  logic [4:0]  word_idx;
  logic [31:0] word_data;
  logic        bus_wr, bus_rd;
  logic [15:0] bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;

  always #2.5 clk = ~clk;

  entry_readback_ctrl #(.POLL_INTERVAL(8), .TIMEOUT_CYC(40)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .index(index), .dual_en(dual_en),
    .busy(busy), .done(done), .timeout_err(timeout_err),
    .word_valid(word_valid), .word_idx(word_idx), .word_data(word_data),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] pat(input int eng, input logic [15:0] idx, input int k);
    return {4'(eng + 1), 4'hA, 8'(k), idx};
  endfunction

  // register model
  int cyc = 0;
  int ack_delay = 0;
  int wr_count, ctrl_rd_count, data_rd_count, gap_err, addr_err;
  int wr_cyc, first_poll_cyc, last_poll_cyc;
  logic [15:0] wr_addr;
  logic [31:0] wr_data;
  logic [15:0] m_idx = '0;
  int m_eng = 0;

  always @(posedge clk) begin
    cyc++;
    bus_rdata <= '0;
    if (rst_n && bus_wr) begin
      wr_count++;
      wr_addr = bus_addr;
      wr_data = bus_wdata;
      wr_cyc  = cyc;
      m_idx   = bus_wdata[15:0];
      m_eng   = (bus_addr == 16'h0300) ? 1 : 0;
    end
    if (rst_n && bus_rd) begin
      if (bus_addr == 16'h0200 || bus_addr == 16'h0300) begin
        ctrl_rd_count++;
        if (ctrl_rd_count == 1) first_poll_cyc = cyc;
        else if (cyc - last_poll_cyc != 8) gap_err++;
        last_poll_cyc = cyc;
        if (ack_delay != 0 && ctrl_rd_count >= ack_delay) bus_rdata <= 32'h0002_0000;
      end else begin
        if (bus_addr != 16'(16'h0204 + m_eng * 16'h0100 + 4 * data_rd_count)) addr_err++;
        bus_rdata <= pat(m_eng, m_idx, data_rd_count);
        data_rd_count++;
      end
    end
  end

  // scoreboard
  int          exp_k[$];
  logic [31:0] exp_d[$];
  int words_seen, done_cnt;
  bit done_with_last;

  always @(negedge clk) begin
    if (rst_n) begin
      if (word_valid) begin
        words_seen++;
        if (exp_k.size() == 0) begin
          chk(1'b0, "R8 unexpected word", 64'(word_idx), 64'hffff);
        end else begin
          int k;
          logic [31:0] d;
          k = exp_k.pop_front();
          d = exp_d.pop_front();
          chk(word_idx == 5'(k), "R8 word index", 64'(word_idx), 64'(k));
          chk(word_data == d, "R8 word data", 64'(word_data), 64'(d));
        end
        if (done) done_with_last = 1;
      end
      if (done) done_cnt++;
    end
  end

  task automatic clear_counts(input int ackd);
    wr_count = 0; ctrl_rd_count = 0; data_rd_count = 0; gap_err = 0; addr_err = 0;
    words_seen = 0; done_cnt = 0; done_with_last = 0; ack_delay = ackd;
  endtask

  task automatic pulse_start(input logic [15:0] idx, input bit dual);
    @(negedge clk);
    index = idx; dual_en = dual; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done(output int n);
    n = 0;
    while (!done) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic run_op(input logic [15:0] idx, input bit dual, input int ackd, input bit poke_busy);
    bit inr;
    int eng, n;
    inr = idx < 16'd16384;
    eng = (dual && idx >= 16'd8192) ? 1 : 0;
    clear_counts(ackd);
    if (inr && ackd > 0)
      for (int k = 0; k < NW; k++) begin
        exp_k.push_back(k);
        exp_d.push_back(pat(eng, idx, k));
      end
    pulse_start(idx, dual);
    if (inr) chk(timeout_err == 1'b0, "R11 error cleared on start", 64'(timeout_err), 0);
    if (poke_busy) begin
      repeat (3) @(negedge clk);
      index = 16'hFFFF; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    wait_done(n);
    if (!inr) chk(n == 0, "R2 done one cycle after start", 64'(n), 0);
    @(negedge clk);
    chk(!busy && !done, "R9 idle after done", {busy, done}, 0);
    if (!inr) begin
      chk(wr_count + ctrl_rd_count + data_rd_count == 0, "R2 no bus access",
          64'(wr_count + ctrl_rd_count + data_rd_count), 0);
      chk(words_seen == 0, "R2 no words", 64'(words_seen), 0);
    end else begin
      chk(wr_count == 1, "R4 one write", 64'(wr_count), 1);
      chk(wr_addr == 16'(16'h0200 + eng * 16'h0100), "R3 control address", 64'(wr_addr),
          64'(16'h0200 + eng * 16'h0100));
      chk(wr_data == (32'h0001_0000 | 32'(idx)), "R4 request word", 64'(wr_data),
          64'(32'h0001_0000 | 32'(idx)));
      chk(first_poll_cyc == wr_cyc + 1, "R5 first poll follows write",
          64'(first_poll_cyc - wr_cyc), 1);
      chk(gap_err == 0, "R5 poll spacing", 64'(gap_err), 0);
      if (ackd > 0) begin
        chk(ctrl_rd_count == ackd, "R5 polls until ack", 64'(ctrl_rd_count), 64'(ackd));
        chk(data_rd_count == NW, "R7 data read count", 64'(data_rd_count), NW);
        chk(addr_err == 0, "R7 data addresses", 64'(addr_err), 0);
        chk(words_seen == NW && exp_k.size() == 0, "R8 all words streamed", 64'(words_seen), NW);
        chk(done_with_last, "R9 done with last word", 64'(done_with_last), 1);
        chk(timeout_err == 1'b0, "R6 no error on success", 64'(timeout_err), 0);
      end else begin
        chk(ctrl_rd_count == 6, "R6 poll count before timeout", 64'(ctrl_rd_count), 6);
        chk(timeout_err == 1'b1, "R6 timeout flagged", 64'(timeout_err), 1);
        chk(data_rd_count == 0 && words_seen == 0, "R6 no data on timeout",
            64'(data_rd_count + words_seen), 0);
      end
    end
    exp_k.delete();
    exp_d.delete();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; index = '0; dual_en = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk({busy, done, word_valid, timeout_err, bus_wr, bus_rd} == 6'b0, "R1 reset state",
        64'({busy, done, word_valid, timeout_err, bus_wr, bus_rd}), 0);

    run_op(16'd100,   1'b0, 1, 1'b0);   // engine 0
    run_op(16'd9000,  1'b1, 3, 1'b0);   // R3 engine 1, late ack
    run_op(16'd9000,  1'b0, 2, 1'b0);   // R3 single engine
    run_op(16'd8192,  1'b1, 1, 1'b0);   // R3 boundary -> engine 1
    run_op(16'd8191,  1'b1, 1, 1'b0);   // R3 below boundary -> engine 0
    run_op(16'd16384, 1'b1, 1, 1'b0);   // R2 first external index
    run_op(16'hFFFF,  1'b0, 1, 1'b0);   // R2 top index
    run_op(16'd500,   1'b0, 0, 1'b0);   // R6 timeout

    repeat (5) @(negedge clk);
    chk(timeout_err == 1'b1, "R11 error held while idle", 64'(timeout_err), 1);
    run_op(16'd7, 1'b0, 1, 1'b0);       // R11 cleared by next start

    run_op(16'd1234, 1'b1, 2, 1'b1);    // R10 start while busy ignored
    repeat (5) @(negedge clk);
    chk(done_cnt == 1 && !busy, "R10 no second operation", 64'(done_cnt), 1);
    chk(wr_count == 1, "R10 no second request", 64'(wr_count), 1);

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule